// File: doc/BRIEF.md
# RGB-to-YCbCr Colour Matrix

This block converts a stream of three-component pixels (10 bits per component) from one colour space to another. It applies a 3x3 signed fixed-point matrix. Before the multiply, a signed offset is added to each input component. After the multiply, the result is rounded, a signed offset is added and the value is clamped. A typical load is the BT.709 limited-range RGB-to-YCbCr set. A single enable bit turns the conversion off, and then pixels leave the block exactly as they entered.

Software writes the coefficients and offsets through a plain address/data write port. These writes go to a pending register set. The pending set becomes the active set only on a frame-start strobe, so no frame is ever converted with a mixture of two sets. A two-state machine tracks whether the pending set holds uncommitted writes:

- `CFG_CLEAN`: the pending set equals the active set. A write moves it to `CFG_DIRTY`; with no write it stays.
- `CFG_DIRTY`: writes are waiting. A frame-start strobe commits them. It then returns to `CFG_CLEAN`, or stays in `CFG_DIRTY` if a write arrives in the same cycle.

The datapath is a three-stage pipeline:

- Stage 1 adds the offsets and forms the products.
- Stage 2 sums the products, rounds and applies the extra shift.
- Stage 3 adds the output offset and clamps.

Top module: `csc_matrix`

## Requirements
- R1: Input offsets are 12-bit two's complement values. Address 0 holds the offset for component 0 in bits [27:16] and the offset for component 1 in bits [11:0]. Address 1 holds the offset for component 2 in bits [11:0]. Each offset is added to its input component before the multiply.
- R2: `out_valid` rises exactly 3 cycles after the `in_valid` cycle that carried the pixel. Each accepted pixel produces exactly one output, in order.
- R3: Coefficients are 13-bit two's complement values, where 1024 means 1.0. They are packed in row-major order: c00/c01 at address 2, c02/c10 at address 3, c11/c12 at address 4 and c20/c21 at address 5, each pair in bits [28:16]/[12:0]. c22 is alone in bits [28:16] of address 6.
- R4: When bit 0 of address 10 is clear in the active set, each output component equals the corresponding input component exactly.
- R5: When the conversion is enabled, output i is computed as follows. Form acc = sum over j of c_ij*(in_j+pre_j). Then take ((acc+512) >>> 10) with an arithmetic floor shift.
- R6: Output offsets are 12-bit two's complement values, packed like the input offsets: components 0/1 at address 7 and component 2 at address 8. Each is added after rounding, and the sum is clamped to 0..1023.
- R7: Writes take no effect until a `frame_start` cycle. A pixel presented in the same cycle as `frame_start` already uses the committed set. A write in the same cycle as `frame_start` waits for the next strobe.
- R8: Bits [18:16] of address 9 give an extra arithmetic right shift, applied after the rounding shift of R5. Bits [31:30] of that register have no effect.
- R9: After reset the pending and active sets are as follows: identity coefficients (1024 on the diagonal), zero offsets, zero shift and conversion disabled. `out_valid` is low.
- R10: Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register word address |
| cfg_wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Commits pending writes to the active set |
| in_valid | input | 1 | Input pixel qualifier |
| in_c0 | input | 10 | Input component 0 (R or first) |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 10 | Output component 0 (Y) |
| out_c1 | output | 10 | Output component 1 (Cb) |
| out_c2 | output | 10 | Output component 2 (Cr) |

## Verification
The bench builds the block with its package defaults. These are 10-bit components, 13-bit coefficients, 12-bit offsets, 10 fractional bits and a 3-bit shift field.

At these widths the full BT.709 set fits without overflow, so both clamp limits can be reached. White with a large positive output offset reaches 1023, and black with a negative one reaches 0. The largest negative input offset pushes the multiplier operand below zero. The tests also cover these cases:

- shift values that make the floor rounding of negative sums visible;
- writes landing exactly on a frame-start strobe.

// File: rtl/csc_pkg.sv
package csc_pkg;
    parameter int unsigned PIX_W    = 10;
    parameter int unsigned COEF_W   = 13;
    parameter int unsigned OFS_W    = 12;
    parameter int unsigned SHIFT_W  = 3;
    parameter int unsigned FRAC_W   = 10;
    parameter int unsigned ADDR_W   = 4;
    parameter int unsigned DATA_W   = 32;
    parameter int unsigned NCH      = 3;
    parameter int unsigned HI_LSB   = 16;

    localparam int unsigned NCOEF = NCH * NCH;

    localparam logic [ADDR_W-1:0] ADR_PRE_A  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_PRE_B  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_COEF_A = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_COEF_B = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_COEF_C = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_COEF_D = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_COEF_E = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_POST_A = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_POST_B = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd10;

    typedef struct packed {
        logic                           en;
        logic [SHIFT_W-1:0]             rshift;
        logic [NCH-1:0][OFS_W-1:0]      pre;
        logic [NCH-1:0][OFS_W-1:0]      post;
        logic [NCOEF-1:0][COEF_W-1:0]   coef;
    } csc_cfg_t;

    typedef enum logic {
        CFG_CLEAN = 1'b0,
        CFG_DIRTY = 1'b1
    } cfg_state_e;

    function automatic csc_cfg_t cfg_reset_value();
        csc_cfg_t c;
        c = '0;
        for (int i = 0; i < NCH; i++) begin
            c.coef[i*NCH+i] = COEF_W'(1 << FRAC_W);
        end
        return c;
    endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output csc_cfg_t          cfg_use
);
    cfg_state_e state_q, state_d;
    csc_cfg_t   shadow_q, shadow_d;
    csc_cfg_t   active_q, active_d;
    logic       commit;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Decode of a write into the pending set
    always_comb begin : p_decode
        shadow_d = shadow_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_PRE_A: begin
                    shadow_d.pre[0] = wr_data[HI_LSB +: OFS_W];
                    shadow_d.pre[1] = wr_data[0 +: OFS_W];
                end
                ADR_PRE_B:  shadow_d.pre[2] = wr_data[0 +: OFS_W];
                ADR_COEF_A: begin
                    shadow_d.coef[0] = wr_data[HI_LSB +: COEF_W];
                    shadow_d.coef[1] = wr_data[0 +: COEF_W];
                end
                ADR_COEF_B: begin
                    shadow_d.coef[2] = wr_data[HI_LSB +: COEF_W];
                    shadow_d.coef[3] = wr_data[0 +: COEF_W];
                end
                ADR_COEF_C: begin
                    shadow_d.coef[4] = wr_data[HI_LSB +: COEF_W];
                    shadow_d.coef[5] = wr_data[0 +: COEF_W];
                end
                ADR_COEF_D: begin
                    shadow_d.coef[6] = wr_data[HI_LSB +: COEF_W];
                    shadow_d.coef[7] = wr_data[0 +: COEF_W];
                end
                ADR_COEF_E: shadow_d.coef[8] = wr_data[HI_LSB +: COEF_W];
                ADR_POST_A: begin
                    shadow_d.post[0] = wr_data[HI_LSB +: OFS_W];
                    shadow_d.post[1] = wr_data[0 +: OFS_W];
                end
                ADR_POST_B: shadow_d.post[2] = wr_data[0 +: OFS_W];
                ADR_MODE:   shadow_d.rshift  = wr_data[HI_LSB +: SHIFT_W];
                ADR_CTRL:   shadow_d.en      = wr_data[0];
                default: ;
            endcase
        end
    end

    // Next-state logic of the commit machine
    always_comb begin : p_next
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN: state_d = wr_en ? CFG_DIRTY : CFG_CLEAN;
            CFG_DIRTY: begin
                if (frame_start) begin
                    state_d = wr_en ? CFG_DIRTY : CFG_CLEAN;
                end
            end
            default: state_d = CFG_CLEAN;
        endcase
    end

    // Outputs of the commit machine
    always_comb begin : p_out
        commit   = frame_start && (state_q == CFG_DIRTY);
        active_d = commit ? shadow_q : active_q;
        cfg_use  = commit ? shadow_q : active_q;
    end

    always_ff @(posedge clk) begin : p_state
        if (!rst_n) begin
            state_q  <= CFG_CLEAN;
            shadow_q <= cfg_reset_value();
            active_q <= cfg_reset_value();
        end else begin
            state_q  <= state_d;
            shadow_q <= shadow_d;
            active_q <= active_d;
        end
    end

    AST_ACTIVE_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> $past(frame_start)); // R7

    AST_WRITE_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q == CFG_DIRTY)); // R7

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !wr_en) |=> (state_q == CFG_CLEAN)); // R7
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [NCH-1:0][PIX_W-1:0]    in_pix,
    input  csc_cfg_t                     cfg,
    output logic                         out_valid,
    output logic [NCH-1:0][PIX_W-1:0]    out_pix
);
    localparam int unsigned OPD_W  = OFS_W + 1;
    localparam int unsigned PROD_W = COEF_W + OPD_W;
    localparam int unsigned ACC_W  = PROD_W + 2;
    localparam int unsigned SUM_W  = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [OPD_W-1:0]  opnd [NCH];
    logic signed [PROD_W-1:0] prod_d [NCH][NCH];
    logic signed [PROD_W-1:0] prod_q [NCH][NCH];
    logic signed [ACC_W-1:0]  scaled_d [NCH];
    logic signed [ACC_W-1:0]  scaled_q [NCH];
    logic [NCH-1:0][PIX_W-1:0] clip_d;

    logic [NCH-1:0][PIX_W-1:0] byp1_q, byp2_q;
    logic [NCH-1:0][OFS_W-1:0] post1_q, post2_q;
    logic [SHIFT_W-1:0]        sh1_q;
    logic                      en1_q, en2_q;
    logic [2:0]                vld_q;

    // Stage 1: input offset and products
    for (genvar j = 0; j < NCH; j++) begin : g_opnd
        assign opnd[j] = $signed({{(OPD_W-PIX_W){1'b0}}, in_pix[j]})
                       + $signed({cfg.pre[j][OFS_W-1], cfg.pre[j]});
    end
    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = 0; j < NCH; j++) begin : g_col
            assign prod_d[i][j] = $signed(cfg.coef[i*NCH+j]) * opnd[j];
        end
        // Stage 2: sum, round, extra shift
        always_comb begin : p_scale
            logic signed [ACC_W-1:0] acc;
            acc = ACC_W'(prod_q[i][0]) + ACC_W'(prod_q[i][1]) + ACC_W'(prod_q[i][2]);
            scaled_d[i] = ((acc + RND) >>> FRAC_W) >>> sh1_q;
        end
        // Stage 3: output offset and clamp
        always_comb begin : p_clip
            logic signed [SUM_W-1:0] s;
            s = SUM_W'(scaled_q[i]) + SUM_W'($signed(post2_q[i]));
            if (s < 0)             clip_d[i] = '0;
            else if (s > PIX_MAX)  clip_d[i] = '1;
            else                   clip_d[i] = s[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin : p_pipe
        for (int i = 0; i < NCH; i++) begin
            for (int j = 0; j < NCH; j++) begin
                prod_q[i][j] <= prod_d[i][j];
            end
            scaled_q[i] <= scaled_d[i];
        end
        byp1_q  <= in_pix;
        byp2_q  <= byp1_q;
        post1_q <= cfg.post;
        post2_q <= post1_q;
        sh1_q   <= cfg.rshift;
        en1_q   <= cfg.en;
        en2_q   <= en1_q;
        out_pix <= en2_q ? clip_d : byp2_q;
    end

    always_ff @(posedge clk) begin : p_valid
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[1:0], in_valid};
    end
    assign out_valid = vld_q[2];

    AST_OUT_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)); // R2

    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cfg.en, 3)) |-> (out_pix == $past(in_pix, 3))); // R4
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);
    csc_cfg_t                  cfg_use;
    logic [NCH-1:0][PIX_W-1:0] pix_in, pix_out;

    assign pix_in = {in_c2, in_c1, in_c0};

    csc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_addr     (cfg_wr_addr),
        .wr_data     (cfg_wr_data),
        .frame_start (frame_start),
        .cfg_use     (cfg_use)
    );

    csc_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (pix_in),
        .cfg       (cfg_use),
        .out_valid (out_valid),
        .out_pix   (pix_out)
    );

    assign out_c0 = pix_out[0];
    assign out_c1 = pix_out[1];
    assign out_c2 = pix_out[2];
endmodule

// File: tb/csc_matrix_test.sv
module csc_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_valid;
    logic [9:0]  out_c0, out_c1, out_c2;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int pre[3];
        int coef[9];
        int post[3];
        int sh;
        int en;
    } model_t;

    model_t pend, act;
    logic [29:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csc_matrix uut (.*);

    function automatic int sx(int v, int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic model_t reset_model();
        model_t m;
        m.pre = '{0, 0, 0};
        m.post = '{0, 0, 0};
        m.coef = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        m.sh = 0;
        m.en = 0;
        return m;
    endfunction

    function automatic model_t apply_wr(model_t m, logic [3:0] a, logic [31:0] d);
        int hi12, lo12, hi13, lo13;
        hi12 = sx(int'(d[27:16]), 12); lo12 = sx(int'(d[11:0]), 12);
        hi13 = sx(int'(d[28:16]), 13); lo13 = sx(int'(d[12:0]), 13);
        case (a)
            4'd0: begin m.pre[0] = hi12; m.pre[1] = lo12; end
            4'd1: m.pre[2] = lo12;
            4'd2: begin m.coef[0] = hi13; m.coef[1] = lo13; end
            4'd3: begin m.coef[2] = hi13; m.coef[3] = lo13; end
            4'd4: begin m.coef[4] = hi13; m.coef[5] = lo13; end
            4'd5: begin m.coef[6] = hi13; m.coef[7] = lo13; end
            4'd6: m.coef[8] = hi13;
            4'd7: begin m.post[0] = hi12; m.post[1] = lo12; end
            4'd8: m.post[2] = lo12;
            4'd9: m.sh = int'(d[18:16]);
            4'd10: m.en = int'(d[0]);
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic [29:0] predict(model_t m, int a, int b, int c);
        int px[3];
        longint acc, r;
        logic [29:0] res;
        px = '{a, b, c};
        for (int i = 0; i < 3; i++) begin
            if (m.en == 0) begin
                r = px[i];
            end else begin
                acc = 0;
                for (int j = 0; j < 3; j++)
                    acc += longint'(m.coef[i*3+j]) * longint'(px[j] + m.pre[j]);
                r = (acc + 512) >>> 10;
                r = r >>> m.sh;
                r = r + m.post[i];
                if (r < 0) r = 0;
                if (r > 1023) r = 1023;
            end
            res[29-10*i -: 10] = 10'(r);
        end
        return res;
    endfunction

    task automatic step(input bit fs, input bit we, input logic [3:0] a,
                        input logic [31:0] d, input bit pv,
                        input int p0, input int p1, input int p2, input string tag);
        model_t use_m;
        @(negedge clk);
        frame_start = fs; cfg_wr_en = we; cfg_wr_addr = a; cfg_wr_data = d;
        in_valid = pv; in_c0 = 10'(p0); in_c1 = 10'(p1); in_c2 = 10'(p2);
        use_m = fs ? pend : act;
        if (pv) begin
            exp_q.push_back(predict(use_m, p0, p1, p2));
            tag_q.push_back(tag);
            cyc_q.push_back(cyc);
        end
        if (fs) act = pend;
        if (we) pend = apply_wr(pend, a, d);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d, 1'b0, 0, 0, 0, "");
    endtask

    task automatic pix(input int p0, input int p1, input int p2, input string tag);
        step(1'b0, 1'b0, 4'd0, 32'd0, 1'b1, p0, p1, p2, tag);
    endtask

    task automatic fs_pix(input int p0, input int p1, input int p2, input string tag);
        step(1'b1, 1'b0, 4'd0, 32'd0, 1'b1, p0, p1, p2, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 4'd0, 32'd0, 1'b0, 0, 0, 0, "");
    endtask

    function automatic logic [31:0] pk(int hi, int lo, int w);
        logic [31:0] d;
        d = '0;
        d[16 +: 13] = 13'(hi) & 13'((1 << w) - 1);
        d[0 +: 13]  = 13'(lo) & 13'((1 << w) - 1);
        return d;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: out_valid with no pixel pending, actual %h expected none",
                         {out_c0, out_c1, out_c2});
            end else begin
                logic [29:0] e;
                string t;
                int c0;
                e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
                if ({out_c0, out_c1, out_c2} !== e || cyc - c0 != 3) begin
                    n_bad++;
                    $display("FAIL %s: actual %h (latency %0d) expected %h (latency 3)",
                             t, {out_c0, out_c1, out_c2}, cyc - c0, e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        pend = reset_model();
        act  = reset_model();
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: out_valid in reset actual %b expected 0", out_valid);
        end
        @(negedge clk); rst_n = 1'b1;

        // R9 / R4: reset set, bypass, back-to-back pixels
        pix(0, 0, 0, "R9 reset bypass black");
        pix(1023, 512, 5, "R4 bypass mixed");
        pix(100, 200, 300, "R4 bypass ramp");
        idle(4);

        // R5: enable with identity
        wr(4'd10, 32'd1);
        fs_pix(777, 3, 1000, "R5 identity enabled, R7 same-cycle commit");
        pix(1, 1022, 512, "R5 identity enabled");
        idle(4);

        // R3 / R6: BT.709 limited-range set
        wr(4'd2, pk(186, 627, 13));
        wr(4'd3, pk(63, -103, 13));
        wr(4'd4, pk(-345, 448, 13));
        wr(4'd5, pk(448, -407, 13));
        wr(4'd6, pk(-41, 0, 13));
        wr(4'd7, pk(64, 512, 12));
        wr(4'd8, pk(0, 512, 12));
        pix(600, 300, 100, "R7 pending writes not yet used");
        fs_pix(0, 0, 0, "R6 black limited range");
        pix(1023, 1023, 1023, "R5 white");
        pix(1023, 0, 0, "R3 red");
        pix(0, 0, 1023, "R3 blue exercises c22");
        pix(512, 256, 768, "R5 mid grey mix");
        idle(4);

        // R7: write in the same cycle as frame_start
        step(1'b1, 1'b1, 4'd10, 32'd0, 1'b1, 200, 400, 600, "R7 write on strobe deferred");
        pix(10, 20, 30, "R7 still enabled");
        fs_pix(10, 20, 30, "R7 bypass after next strobe");
        idle(4);

        // R1: input offsets, including negative ones
        wr(4'd10, 32'd1);
        wr(4'd0, pk(-64, 100, 12));
        wr(4'd1, pk(0, -2048, 12));
        fs_pix(64, 923, 1023, "R1 input offsets");
        pix(0, 0, 0, "R1 negative operands");
        idle(4);

        // R6: clamp at both ends
        wr(4'd0, 32'd0); wr(4'd1, 32'd0);
        wr(4'd7, pk(1000, -100, 12));
        wr(4'd8, pk(0, -2048, 12));
        fs_pix(1023, 1023, 1023, "R6 clamp high and low");
        pix(0, 0, 0, "R6 clamp low");
        idle(4);

        // R8: extra shift, bits 31:30 ignored
        wr(4'd7, pk(64, 512, 12)); wr(4'd8, pk(0, 512, 12));
        wr(4'd9, 32'hC001_0000);
        fs_pix(1023, 1023, 1023, "R8 shift by one");
        pix(0, 1023, 0, "R8 negative sum floor shift");
        wr(4'd9, 32'h0007_0000);
        fs_pix(1023, 512, 9, "R8 shift by seven");
        idle(4);

        // R10: unmapped addresses
        wr(4'd11, 32'hFFFF_FFFF); wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd13, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
        fs_pix(1023, 512, 9, "R10 unmapped writes ignored");
        idle(6);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: outputs missing actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule